// File: doc/BRIEF.md
# Serial Software Flow Control Engine

This block carries the in-band Xon/Xoff flow control for one serial channel. It watches each character the receiver delivers and compares it with programmed Xon and Xoff patterns. Each pattern is either one character or a pair of consecutive characters. An Xoff match stops the transmitter from taking new characters out of its FIFO, and an Xon match lets it continue. Matched control characters are consumed and never reach the receive FIFO. Every other character is forwarded one cycle later on a forwarding strobe.

In the other direction, the block watches the receive FIFO fill level. When the level reaches the trigger, it waits two character times, counted in baud ticks, and then injects the Xoff character or characters into the transmitter. When the level later falls to the release point, it injects Xon. The release point is either one trigger step or a hysteresis amount below the trigger. Injected characters win over FIFO data at the transmitter, but only when the shifter is idle, so a character already on the line always completes.

An optional special-character detect compares each received character with the second Xoff pattern. A match sets a flag and the character still goes to the FIFO.

Top module: `swflow_ctrl`

## Requirements
- R1: Comparisons use only the low 5, 6, 7 or 8 bits of a character and pattern, selected by `wlen` = 0, 1, 2 or 3, with bit 0 being the first-received data bit.
- R2: In single mode (`dual_en`=0, `match_en`=1), a received character equal to `xoff1` sets `tx_hold` and `xoff_flag` on the next clock edge. A character equal to `xon1` clears both.
- R3: In pair mode (`dual_en`=1), the hold is set only by `xoff1` immediately followed by `xoff2`. It is cleared only by `xon1` immediately followed by `xon2`.
- R4: A character consumed as flow control is not forwarded. Any other character appears on `fwd_valid`/`fwd_char` one cycle after its strobe. In pair mode, a held first character whose partner fails to match is forwarded one cycle after the failing character's strobe, and the failing character follows one cycle later. Received strobes are at least two cycles apart.
- R5: `load_fifo` is high only when `tx_idle` and `fifo_avail` are high, `tx_hold` is low, and no control character is waiting to be sent.
- R6: A waiting control character is offered on `load_ctrl`/`ctrl_char` whenever `tx_idle` is high, even while `tx_hold` is set. Neither load is ever raised while `tx_idle` is low.
- R7: With `auto_tx_en` set, once `fifo_lvl` ≥ `trig_lvl`, the Xoff character is offered after 2 × (1 + data bits + parity bit + stop bits) baud ticks. With `baud_tick` held high, this is that many cycles plus one.
- R8: After Xoff has been sent, Xon is offered once `fifo_lvl` ≤ the release point. The release point is `trig_lvl`−`step_lvl` when `hyst_mode`=0 and `trig_lvl`−`hyst_lvl` when `hyst_mode`=1, floored at 0.
- R9: In pair mode, the block sends pattern 1 and then pattern 2 on consecutive loads, for both Xoff and Xon.
- R10: With `spc_en` set, a character equal to `xoff2` is forwarded, sets `spc_flag`, and is never treated as flow control. `flag_clr` clears `spc_flag`.
- R11: `irq` is high exactly when (`xoff_flag` and `xoff_ie`) or (`spc_flag` and `spc_ie`).
- R12: After reset, `tx_hold`, both flags, `irq`, `fwd_valid` and `load_ctrl` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| fwd_valid | output | 1 | Write strobe toward the receive FIFO |
| fwd_char | output | 8 | Character written to the receive FIFO |
| wlen | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Two stop bits |
| match_en | input | 1 | Enable received pattern matching |
| dual_en | input | 1 | Pair-of-characters patterns |
| spc_en | input | 1 | Special-character detect |
| auto_tx_en | input | 1 | Enable automatic Xoff/Xon sending |
| hyst_mode | input | 1 | Release by hysteresis instead of trigger step |
| xon1 | input | 8 | Xon pattern, first character |
| xon2 | input | 8 | Xon pattern, second character |
| xoff1 | input | 8 | Xoff pattern, first character |
| xoff2 | input | 8 | Xoff pattern, second character / special character |
| fifo_lvl | input | LVL_W | Receive FIFO fill level |
| trig_lvl | input | LVL_W | Trigger level |
| step_lvl | input | LVL_W | Distance to the next lower trigger |
| hyst_lvl | input | LVL_W | Hysteresis amount |
| baud_tick | input | 1 | One pulse per bit time |
| tx_idle | input | 1 | Transmit shifter can accept a character |
| fifo_avail | input | 1 | Transmit FIFO has a character |
| load_fifo | output | 1 | Move the next FIFO character into the shifter |
| load_ctrl | output | 1 | Move `ctrl_char` into the shifter |
| ctrl_char | output | 8 | Control character to send |
| tx_hold | output | 1 | Transmission suspended by remote Xoff |
| xoff_ie | input | 1 | Interrupt enable for Xoff status |
| spc_ie | input | 1 | Interrupt enable for special character |
| flag_clr | input | 1 | Clear the special-character flag |
| xoff_flag | output | 1 | Xoff received status |
| spc_flag | output | 1 | Special character seen |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends characters that differ from a pattern only above the selected word length. A wrong mask would either miss these matches or start matching on bits outside the word. It breaks a pair halfway through to check the ordering of the two forwards: a design that drops or reorders the held character would lose data. It counts cycles from the trigger crossing to the first injected Xoff for two frame formats, and a miscount of parity or stop bits shows up as an off-by-two. It also steps the FIFO level one entry above and then onto the release point in both release modes, and it makes the special character equal the Xoff pattern, so a design that let flow control consume it would freeze the transmitter.

// File: rtl/swflow_ctrl.sv
module swflow_ctrl #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_char,
  output logic             fwd_valid,
  output logic [7:0]       fwd_char,
  input  logic [1:0]       wlen,
  input  logic             par_en,
  input  logic             stop2,
  input  logic             match_en,
  input  logic             dual_en,
  input  logic             spc_en,
  input  logic             auto_tx_en,
  input  logic             hyst_mode,
  input  logic [7:0]       xon1,
  input  logic [7:0]       xon2,
  input  logic [7:0]       xoff1,
  input  logic [7:0]       xoff2,
  input  logic [LVL_W-1:0] fifo_lvl,
  input  logic [LVL_W-1:0] trig_lvl,
  input  logic [LVL_W-1:0] step_lvl,
  input  logic [LVL_W-1:0] hyst_lvl,
  input  logic             baud_tick,
  input  logic             tx_idle,
  input  logic             fifo_avail,
  output logic             load_fifo,
  output logic             load_ctrl,
  output logic [7:0]       ctrl_char,
  output logic             tx_hold,
  input  logic             xoff_ie,
  input  logic             spc_ie,
  input  logic             flag_clr,
  output logic             xoff_flag,
  output logic             spc_flag,
  output logic             irq
);

  typedef enum logic [1:0] {K_NONE, K_ON, K_OFF} kind_t;
  typedef enum logic [2:0] {A_IDLE, A_WAIT, A_OFF, A_HELD, A_ON} auto_t;

  function automatic logic eqm(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m);
    return ((a ^ b) & m) == 8'd0;
  endfunction

  logic [7:0] mask;
  logic       spc_hit, fc, on1, on2, off1, off2;
  kind_t      held_k;
  logic [7:0] held_d, pend_d;
  logic       pend_v, susp;

  assign mask    = 8'hFF >> (2'd3 - wlen);
  assign spc_hit = spc_en & eqm(rx_char, xoff2, mask);
  assign fc      = match_en & ~spc_hit;
  assign on1     = fc & eqm(rx_char, xon1, mask);
  assign on2     = fc & eqm(rx_char, xon2, mask);
  assign off1    = fc & eqm(rx_char, xoff1, mask);
  assign off2    = fc & eqm(rx_char, xoff2, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_char  <= 8'd0;
      held_k    <= K_NONE;
      held_d    <= 8'd0;
      pend_v    <= 1'b0;
      pend_d    <= 8'd0;
      susp      <= 1'b0;
      xoff_flag <= 1'b0;
      spc_flag  <= 1'b0;
    end else begin
      fwd_valid <= 1'b0;
      if (flag_clr) spc_flag <= 1'b0;
      if (pend_v) begin
        fwd_valid <= 1'b1;
        fwd_char  <= pend_d;
        pend_v    <= 1'b0;
      end
      if (rx_valid) begin
        if (spc_hit) spc_flag <= 1'b1;
        if (!dual_en) begin
          if (off1) begin
            susp <= 1'b1; xoff_flag <= 1'b1;
          end else if (on1) begin
            susp <= 1'b0; xoff_flag <= 1'b0;
          end else begin
            fwd_valid <= 1'b1; fwd_char <= rx_char;
          end
        end else if (held_k == K_OFF && off2) begin
          susp <= 1'b1; xoff_flag <= 1'b1; held_k <= K_NONE;
        end else if (held_k == K_ON && on2) begin
          susp <= 1'b0; xoff_flag <= 1'b0; held_k <= K_NONE;
        end else begin
          if (held_k != K_NONE) begin
            fwd_valid <= 1'b1; fwd_char <= held_d;
          end
          if (off1) begin
            held_k <= K_OFF; held_d <= rx_char;
          end else if (on1) begin
            held_k <= K_ON; held_d <= rx_char;
          end else begin
            held_k <= K_NONE;
            if (held_k != K_NONE) begin
              pend_v <= 1'b1; pend_d <= rx_char;
            end else begin
              fwd_valid <= 1'b1; fwd_char <= rx_char;
            end
          end
        end
      end
    end
  end

  auto_t            ast;
  logic             idx;
  logic [6:0]       cnt, dly;
  logic [5:0]       nbits;
  logic [LVL_W-1:0] sub, rel;
  logic             sending;

  assign nbits   = 6'd7 + {4'd0, wlen} + {5'd0, par_en} + {5'd0, stop2};
  assign dly     = {nbits, 1'b0};
  assign sub     = hyst_mode ? hyst_lvl : step_lvl;
  assign rel     = (trig_lvl > sub) ? trig_lvl - sub : '0;
  assign sending = (ast == A_OFF) || (ast == A_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ast <= A_IDLE;
      idx <= 1'b0;
      cnt <= 7'd0;
    end else begin
      case (ast)
        A_IDLE: if (auto_tx_en && fifo_lvl >= trig_lvl) begin
          ast <= A_WAIT; cnt <= 7'd0;
        end
        A_WAIT: if (baud_tick) begin
          if (cnt == dly - 7'd1) begin
            ast <= A_OFF; idx <= 1'b0;
          end else cnt <= cnt + 7'd1;
        end
        A_OFF: if (load_ctrl) begin
          if (dual_en && !idx) idx <= 1'b1;
          else begin ast <= A_HELD; idx <= 1'b0; end
        end
        A_HELD: if (fifo_lvl <= rel) ast <= A_ON;
        A_ON: if (load_ctrl) begin
          if (dual_en && !idx) idx <= 1'b1;
          else begin ast <= A_IDLE; idx <= 1'b0; end
        end
        default: ast <= A_IDLE;
      endcase
    end
  end

  assign load_ctrl = sending & tx_idle;
  assign ctrl_char = (ast == A_OFF) ? (idx ? xoff2 : xoff1) : (idx ? xon2 : xon1);
  assign load_fifo = tx_idle & fifo_avail & ~susp & ~sending;
  assign tx_hold   = susp;
  assign irq       = (xoff_flag & xoff_ie) | (spc_flag & spc_ie);

endmodule

// File: rtl/swflow_ctrl_chk.sv
module swflow_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_char,
  input logic [1:0] wlen,
  input logic       match_en,
  input logic       dual_en,
  input logic       spc_en,
  input logic [7:0] xoff1,
  input logic       tx_idle,
  input logic       load_fifo,
  input logic       load_ctrl,
  input logic       tx_hold,
  input logic       xoff_flag,
  input logic       xoff_ie,
  input logic       irq
);

  a_r5_no_fifo_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hold |-> !load_fifo);

  a_r6_ctrl_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_ctrl |-> !load_fifo);

  a_r6_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fifo || load_ctrl) |-> tx_idle);

  a_r11_irq_xoff: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_flag && xoff_ie) |-> irq);

  a_r2_xoff_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && match_en && !dual_en && !spc_en && wlen == 2'd3 && rx_char == xoff1)
      |=> (tx_hold && xoff_flag));

endmodule

bind swflow_ctrl swflow_ctrl_chk u_chk (.*);

// File: tb/swflow_ctrl_test.sv
module swflow_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 8;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0; logic [7:0] rx_char = 0;
  logic fwd_valid; logic [7:0] fwd_char;
  logic [1:0] wlen = 2'd3;
  logic par_en = 0, stop2 = 0, match_en = 1, dual_en = 0, spc_en = 0, auto_tx_en = 0, hyst_mode = 0;
  logic [7:0] xon1 = 8'h11, xon2 = 8'h22, xoff1 = 8'h13, xoff2 = 8'h23;
  logic [LW-1:0] fifo_lvl = 0, trig_lvl = 8'd16, step_lvl = 8'd8, hyst_lvl = 8'd4;
  logic baud_tick = 1, tx_idle = 1, fifo_avail = 0;
  logic load_fifo, load_ctrl, tx_hold, xoff_flag, spc_flag, irq;
  logic [7:0] ctrl_char;
  logic xoff_ie = 0, spc_ie = 0, flag_clr = 0;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swflow_ctrl #(.LVL_W(LW)) uut (.*);

  // {wlen, char, expect forwarded, expect hold}
  localparam logic [11:0] VEC [12] = '{
    {2'd3, 8'h41, 1'b1, 1'b0}, {2'd3, 8'h13, 1'b0, 1'b1},
    {2'd3, 8'h42, 1'b1, 1'b1}, {2'd3, 8'h11, 1'b0, 1'b0},
    {2'd3, 8'h53, 1'b1, 1'b0}, {2'd2, 8'h93, 1'b0, 1'b1},
    {2'd2, 8'h91, 1'b0, 1'b0}, {2'd0, 8'h33, 1'b0, 1'b1},
    {2'd0, 8'hF1, 1'b0, 1'b0}, {2'd1, 8'h53, 1'b0, 1'b1},
    {2'd1, 8'h51, 1'b0, 1'b0}, {2'd3, 8'h93, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_rx(input logic [7:0] ch);
    @(negedge clk); rx_valid = 1; rx_char = ch;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic count_to_ctrl(output int n);
    n = 0;
    while (!load_ctrl && n < 200) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 hold", tx_hold, 0); chk("R12 xoff_flag", xoff_flag, 0);
    chk("R12 spc_flag", spc_flag, 0); chk("R12 irq", irq, 0);
    chk("R12 fwd_valid", fwd_valid, 0); chk("R12 load_ctrl", load_ctrl, 0);

    // R1 R2 R4 single-mode table
    foreach (VEC[i]) begin
      wlen = VEC[i][11:10];
      pulse_rx(VEC[i][9:2]);
      chk($sformatf("R4 fwd vec%0d", i), fwd_valid, VEC[i][1]);
      if (VEC[i][1]) chk($sformatf("R4 fwd_char vec%0d", i), fwd_char, VEC[i][9:2]);
      chk($sformatf("R1 R2 hold vec%0d", i), tx_hold, VEC[i][0]);
      chk($sformatf("R2 flag vec%0d", i), xoff_flag, VEC[i][0]);
      @(negedge clk);
    end
    wlen = 2'd3;

    // R11 interrupt gating
    pulse_rx(8'h13);
    chk("R11 irq masked", irq, 0);
    xoff_ie = 1; #1;
    chk("R11 irq enabled", irq, 1);
    // R5 FIFO load gated by hold and idle
    fifo_avail = 1; #1;
    chk("R5 blocked by hold", load_fifo, 0);
    pulse_rx(8'h11);
    chk("R11 irq cleared", irq, 0);
    chk("R5 load when free", load_fifo, 1);
    tx_idle = 0; #1;
    chk("R5 no load when busy", load_fifo, 0);
    tx_idle = 1; xoff_ie = 0;

    // R3 R4 pair mode
    dual_en = 1;
    pulse_rx(8'h13);
    chk("R3 first half held", tx_hold, 0); chk("R4 first half not fwd", fwd_valid, 0);
    pulse_rx(8'h23);
    chk("R3 pair xoff", tx_hold, 1); chk("R4 pair not fwd", fwd_valid, 0);
    @(negedge clk);
    chk("R4 nothing late", fwd_valid, 0);
    pulse_rx(8'h11); pulse_rx(8'h13);
    chk("R3 xon1+xoff1 no release", tx_hold, 1);
    chk("R4 held xon1 flushed", fwd_char, 8'h11);
    pulse_rx(8'h22);
    chk("R3 broken pair no effect", tx_hold, 1);
    chk("R4 held xoff1 flushed", fwd_char, 8'h13);
    @(negedge clk);
    pulse_rx(8'h11); pulse_rx(8'h22);
    chk("R3 pair xon", tx_hold, 0);
    pulse_rx(8'h13); pulse_rx(8'h41);
    chk("R4 held first fwd", fwd_valid, 1); chk("R4 held char", fwd_char, 8'h13);
    @(negedge clk);
    chk("R4 failing char fwd", fwd_valid, 1); chk("R4 failing char", fwd_char, 8'h41);
    chk("R3 no hold", tx_hold, 0);
    dual_en = 0;

    // R10 special char wins over flow control
    spc_en = 1; spc_ie = 1; xoff1 = 8'h23;
    pulse_rx(8'h23);
    chk("R10 special fwd", fwd_valid, 1); chk("R10 special char", fwd_char, 8'h23);
    chk("R10 flag", spc_flag, 1); chk("R10 no hold", tx_hold, 0);
    chk("R11 irq special", irq, 1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk("R10 flag cleared", spc_flag, 0);
    spc_en = 0; spc_ie = 0; xoff1 = 8'h13;

    // R7 R6 R8 auto send, 8N1, step release
    pulse_rx(8'h13);
    auto_tx_en = 1;
    fifo_lvl = 8'd16;
    count_to_ctrl(n);
    chk("R7 delay 8N1", n, 21);
    chk("R6 ctrl while held", load_ctrl, 1);
    chk("R6 fifo not loaded", load_fifo, 0);
    chk("R6 xoff char", ctrl_char, 8'h13);
    @(negedge clk);
    chk("R7 single xoff only", load_ctrl, 0);
    fifo_lvl = 8'd9; repeat (3) @(negedge clk);
    chk("R8 above release", load_ctrl, 0);
    fifo_lvl = 8'd8; @(negedge clk);
    chk("R8 xon at step point", load_ctrl, 1);
    chk("R8 xon char", ctrl_char, 8'h11);
    @(negedge clk);
    chk("R8 xon done", load_ctrl, 0);

    // R7 R9 R8 pair send, 7E2, hysteresis release
    dual_en = 1; wlen = 2'd2; par_en = 1; stop2 = 1; hyst_mode = 1;
    fifo_lvl = 8'd20;
    count_to_ctrl(n);
    chk("R7 delay 7E2", n, 23);
    chk("R9 xoff first", ctrl_char, 8'h13);
    @(negedge clk);
    chk("R9 second load", load_ctrl, 1); chk("R9 xoff second", ctrl_char, 8'h23);
    @(negedge clk);
    chk("R9 pair done", load_ctrl, 0);
    fifo_lvl = 8'd13; repeat (3) @(negedge clk);
    chk("R8 above hyst point", load_ctrl, 0);
    tx_idle = 0; fifo_lvl = 8'd12; repeat (2) @(negedge clk);
    chk("R6 no load while busy", load_ctrl, 0);
    tx_idle = 1; #1;
    chk("R8 xon at hyst point", load_ctrl, 1); chk("R9 xon first", ctrl_char, 8'h11);
    @(negedge clk);
    chk("R9 xon second", ctrl_char, 8'h22);
    @(negedge clk);
    chk("R9 xon done", load_ctrl, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule